// File: doc/BRIEF.md
# Two-Category Parking Occupancy Tracker

This block keeps a running count of how many vehicles of each of two categories are inside a parking facility. Each category has a fixed number of slots. A vehicle arriving at the gate raises an arrival strobe together with its category. If that category still has room, the block takes a slot, increments the category count and reports the level the vehicle should park on. Category 0 parks on level 1 and category 1 parks on level 2. If the category is already full, the block reports FULL and leaves the count unchanged.

A departing vehicle raises a departure strobe with its category. The block frees a slot and reports which level the vehicle left from. A departure for a category whose count is already zero has no effect. When an arrival and a departure are both presented in the same cycle, the arrival is served and the departure is dropped.

The status and both counts are driven combinationally from the registered state and the current request. The result is therefore visible in the same cycle as the request, and the registered state takes that result at the next rising clock edge. The block is placed in the gate controller next to the barrier logic, which reads the status in the cycle of the request.

Top module: `park_occupancy_tracker`

## Requirements
- R1: While `rst_n` is low, `status` reads 2 (FULL) and both counts read 0. Once `rst_n` is high, counting starts from zero.
- R2: Neither count ever exceeds the per-category capacity `SLOTS`, which is 5 by default.
- R3: An arrival of category 0 (`arr_cat`=0) while `occ_a` < `SLOTS` raises `occ_a` by one and drives `status` 0 (level 1). An arrival of category 1 while `occ_b` < `SLOTS` raises `occ_b` by one and drives `status` 1 (level 2). In both cases the other category's count is unchanged.
- R4: An arrival whose category count equals `SLOTS` drives `status` 2 (FULL) and leaves both counts unchanged.
- R5: A departure with no arrival present, for a category with a nonzero count, lowers that count by one. It drives `status` 3 for category 0 (left level 1) and 4 for category 1 (left level 2).
- R6: A departure for a category whose count is 0 leaves that count at 0 and leaves `status` at its previous value.
- R7: When `arr_vld` and `dep_vld` are both high in one cycle, only the arrival is applied. The departure changes neither count.
- R8: The response to a request appears on `status`, `occ_a` and `occ_b` in the same cycle as the request. The registered state takes that response at the next rising edge of `clk`.
- R9: In a cycle with neither strobe high, `status`, `occ_a` and `occ_b` keep the values shown in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| arr_vld | input | 1 | Arrival request strobe |
| arr_cat | input | 1 | Category of the arriving vehicle (0 or 1) |
| dep_vld | input | 1 | Departure request strobe |
| dep_cat | input | 1 | Category of the departing vehicle (0 or 1) |
| status | output | 3 | 0 level 1, 1 level 2, 2 full, 3 left level 1, 4 left level 2 |
| occ_a | output | CNT_W (3) | Current count of category 0 |
| occ_b | output | CNT_W (3) | Current count of category 1 |

## Verification
The bench sends bursts of same-category arrivals up to and past capacity. These show whether the full limit is enforced per category or shared between the two. Interleaved arrivals and departures of both categories show whether the level codes and the left-level codes are tied to the right category. Departures sent into an empty category separate a clamped count from one that wraps, and idle cycles after each event separate a held status from one that decays. Simultaneous arrival and departure pairs, both for the same category and for opposite categories, with the arriving category both full and not full, show that the departure is dropped and not merged into the result.

// File: rtl/park_pkg.sv
// Package: shared types and constants for the parking occupancy tracker.
// Assumes exactly two vehicle categories; the status codes are fixed
// because downstream gate logic decodes them.
package park_pkg;

    localparam int NUM_CAT = 2;

    typedef enum logic [2:0] {
        ST_LVL1  = 3'd0,
        ST_LVL2  = 3'd1,
        ST_FULL  = 3'd2,
        ST_LEFT1 = 3'd3,
        ST_LEFT2 = 3'd4
    } park_stat_e;

endpackage

// File: rtl/park_cat_slot.sv
// Module: occupancy counter for one category.
// Holds the registered count and exposes its next value combinationally.
// Assumes arr_hit and dep_hit are never both high; the caller resolves
// priority. The count saturates at SLOTS and at zero.
module park_cat_slot #(
    parameter int SLOTS = 5,
    parameter int CNT_W = $clog2(SLOTS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arr_hit,
    input  logic             dep_hit,
    output logic             arr_ok,
    output logic             dep_ok,
    output logic [CNT_W-1:0] cnt_nxt
);

    localparam logic [CNT_W-1:0] CAP = CNT_W'(SLOTS);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    // Decide whether this cycle's request can be honoured.
    always_comb begin
        arr_ok = arr_hit && (cnt_q < CAP);
        dep_ok = dep_hit && (cnt_q != '0);
    end

    // Next count: reset, increment, decrement or hold.
    always_comb begin
        if (!rst_n)
            cnt_nxt = '0;
        else if (arr_ok)
            cnt_nxt = cnt_q + ONE;
        else if (dep_ok)
            cnt_nxt = cnt_q - ONE;
        else
            cnt_nxt = cnt_q;
    end

    // Register the count.
    always_ff @(posedge clk) begin
        cnt_q <= cnt_nxt;
    end

endmodule

// File: rtl/park_status_sel.sv
// Module: status code selection and status register.
// Produces the status for the current request from per-category accept
// flags. If nothing is honoured and no arrival is present, the last
// status is kept. Assumes dep_vld has already been masked by arr_vld.
module park_status_sel
    import park_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               arr_vld,
    input  logic               arr_cat,
    input  logic               dep_vld,
    input  logic               dep_cat,
    input  logic [NUM_CAT-1:0] arr_ok,
    input  logic [NUM_CAT-1:0] dep_ok,
    output park_stat_e         stat_nxt
);

    park_stat_e stat_q;

    // Choose the code for this cycle.
    always_comb begin
        if (!rst_n)
            stat_nxt = ST_FULL;
        else if (arr_vld)
            stat_nxt = arr_ok[arr_cat] ? (arr_cat ? ST_LVL2 : ST_LVL1) : ST_FULL;
        else if (dep_vld && dep_ok[dep_cat])
            stat_nxt = dep_cat ? ST_LEFT2 : ST_LEFT1;
        else
            stat_nxt = stat_q;
    end

    // Register the shown status.
    always_ff @(posedge clk) begin
        stat_q <= stat_nxt;
    end

endmodule

// File: rtl/park_occupancy_tracker.sv
// Module: top of the two-category parking occupancy tracker.
// Arrival wins over departure in the same cycle. Outputs are combinational
// from registered state and the current request (same-cycle response).
// Reset is synchronous, active low.
module park_occupancy_tracker
    import park_pkg::*;
#(
    parameter int SLOTS = 5,
    parameter int CNT_W = $clog2(SLOTS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arr_vld,
    input  logic             arr_cat,
    input  logic             dep_vld,
    input  logic             dep_cat,
    output logic [2:0]       status,
    output logic [CNT_W-1:0] occ_a,
    output logic [CNT_W-1:0] occ_b
);

    logic [NUM_CAT-1:0] arr_ok;
    logic [NUM_CAT-1:0] dep_ok;
    logic [CNT_W-1:0]   cnt_nxt [NUM_CAT];
    logic               dep_eff;
    park_stat_e         stat_nxt;

    // Arrival priority: a departure only counts with no arrival present.
    always_comb begin
        dep_eff = dep_vld && !arr_vld;
    end

    for (genvar c = 0; c < NUM_CAT; c++) begin : g_cat
        park_cat_slot #(
            .SLOTS (SLOTS),
            .CNT_W (CNT_W)
        ) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .arr_hit (arr_vld && (arr_cat == 1'(c))),
            .dep_hit (dep_eff && (dep_cat == 1'(c))),
            .arr_ok  (arr_ok[c]),
            .dep_ok  (dep_ok[c]),
            .cnt_nxt (cnt_nxt[c])
        );
    end

    park_status_sel u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .arr_vld  (arr_vld),
        .arr_cat  (arr_cat),
        .dep_vld  (dep_eff),
        .dep_cat  (dep_cat),
        .arr_ok   (arr_ok),
        .dep_ok   (dep_ok),
        .stat_nxt (stat_nxt)
    );

    // Drive the outputs.
    always_comb begin
        status = stat_nxt;
        occ_a  = cnt_nxt[0];
        occ_b  = cnt_nxt[1];
    end

endmodule

// File: rtl/park_occupancy_chk.sv
// Module: assertion checker for park_occupancy_tracker, attached by bind.
// Keeps its own copy of the last shown outputs, which equals the registered
// state, and relates each cycle's outputs to it.
module park_occupancy_chk #(
    parameter int SLOTS = 5,
    parameter int CNT_W = $clog2(SLOTS + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             arr_vld,
    input logic             arr_cat,
    input logic             dep_vld,
    input logic             dep_cat,
    input logic [2:0]       status,
    input logic [CNT_W-1:0] occ_a,
    input logic [CNT_W-1:0] occ_b
);

    localparam logic [CNT_W-1:0] CAP = CNT_W'(SLOTS);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] prev_a;
    logic [CNT_W-1:0] prev_b;
    logic [2:0]       prev_st;
    logic             pv;

    // Capture the previous outputs and mark them valid once reset was seen.
    always_ff @(posedge clk) begin
        prev_a  <= occ_a;
        prev_b  <= occ_b;
        prev_st <= status;
        if (!rst_n) pv <= 1'b1;
    end

    // R2
    cap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_a <= CAP) && (occ_b <= CAP));

    // R3
    accept_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pv && arr_vld && !arr_cat && (prev_a < CAP)
        |-> (occ_a == prev_a + ONE) && (occ_b == prev_b) && (status == 3'd0));

    // R3
    accept_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pv && arr_vld && arr_cat && (prev_b < CAP)
        |-> (occ_b == prev_b + ONE) && (occ_a == prev_a) && (status == 3'd1));

    // R4
    full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pv && arr_vld && ((arr_cat ? prev_b : prev_a) == CAP)
        |-> (status == 3'd2) && (occ_a == prev_a) && (occ_b == prev_b));

    // R5
    leave_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pv && dep_vld && !arr_vld && !dep_cat && (prev_a != '0)
        |-> (occ_a == prev_a - ONE) && (status == 3'd3));

    // R6
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pv && dep_vld && !arr_vld && ((dep_cat ? prev_b : prev_a) == '0)
        |-> (occ_a == prev_a) && (occ_b == prev_b) && (status == prev_st));

    // R7
    arr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pv && arr_vld && dep_vld
        |-> (status == 3'd0) || (status == 3'd1) || (status == 3'd2));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pv && !arr_vld && !dep_vld
        |-> (occ_a == prev_a) && (occ_b == prev_b) && (status == prev_st));

endmodule

bind park_occupancy_tracker park_occupancy_chk #(
    .SLOTS (SLOTS),
    .CNT_W (CNT_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .arr_vld (arr_vld),
    .arr_cat (arr_cat),
    .dep_vld (dep_vld),
    .dep_cat (dep_cat),
    .status  (status),
    .occ_a   (occ_a),
    .occ_b   (occ_b)
);

// File: tb/sim_park_occupancy_tracker.sv
// Scoreboard bench: the driver pushes expected results computed from the
// requirements; the monitor pops and compares them 1 ns after each negedge.
module sim_park_occupancy_tracker;

    localparam int SLOTS = 5;
    localparam int CNT_W = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             arr_vld = 1'b0;
    logic             arr_cat = 1'b0;
    logic             dep_vld = 1'b0;
    logic             dep_cat = 1'b0;
    logic [2:0]       status;
    logic [CNT_W-1:0] occ_a;
    logic [CNT_W-1:0] occ_b;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [2:0] q_st [$];
    logic [2:0] q_a  [$];
    logic [2:0] q_b  [$];
    string      q_tag[$];

    int m_a  = 0;
    int m_b  = 0;
    int m_st = 2;

    always #2 clk = ~clk;

    park_occupancy_tracker #(.SLOTS(SLOTS), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .arr_vld(arr_vld), .arr_cat(arr_cat),
        .dep_vld(dep_vld), .dep_cat(dep_cat),
        .status(status), .occ_a(occ_a), .occ_b(occ_b)
    );

    // Drive one request and push the result the requirements predict.
    task automatic step(input bit rs, input bit av, input bit ac,
                        input bit dv, input bit dc, input string tag);
        @(negedge clk);
        rst_n = rs; arr_vld = av; arr_cat = ac; dep_vld = dv; dep_cat = dc;
        if (!rs) begin
            m_st = 2; m_a = 0; m_b = 0;
        end else if (av) begin
            if (!ac) begin
                if (m_a < SLOTS) begin m_a++; m_st = 0; end else m_st = 2;
            end else begin
                if (m_b < SLOTS) begin m_b++; m_st = 1; end else m_st = 2;
            end
        end else if (dv) begin
            if (!dc && m_a > 0) begin m_a--; m_st = 3; end
            else if (dc && m_b > 0) begin m_b--; m_st = 4; end
        end
        q_st.push_back(3'(m_st));
        q_a.push_back(3'(m_a));
        q_b.push_back(3'(m_b));
        q_tag.push_back(tag);
    endtask

    // Monitor: compare the same-cycle outputs against the scoreboard.
    always @(negedge clk) begin
        #1;
        if (q_st.size() > 0) begin
            logic [2:0] es, ea, eb;
            string t;
            es = q_st.pop_front(); ea = q_a.pop_front();
            eb = q_b.pop_front();  t  = q_tag.pop_front();
            checks++;
            if (status !== es || occ_a !== ea || occ_b !== eb) begin
                errors++;
                $display("FAIL %s: got st=%0d a=%0d b=%0d exp st=%0d a=%0d b=%0d",
                         t, status, occ_a, occ_b, es, ea, eb);
            end
        end
    end

    initial begin
        step(0, 1, 0, 1, 1, "R1 reset with strobes");
        step(0, 0, 0, 0, 0, "R1 reset");
        step(1, 0, 0, 0, 0, "R1 idle after reset");
        step(1, 1, 0, 0, 0, "R8 same-cycle arrival A");
        step(1, 0, 0, 0, 0, "R8 registered then held");
        for (int i = 0; i < 4; i++) step(1, 1, 0, 0, 0, "R3 arrival A");
        step(1, 1, 0, 0, 0, "R4 A full");
        step(1, 1, 0, 0, 0, "R2 A stays at capacity");
        step(1, 0, 0, 0, 0, "R9 idle after full");
        step(1, 1, 1, 0, 0, "R3 arrival B");
        step(1, 1, 1, 0, 0, "R3 arrival B");
        step(1, 0, 0, 1, 0, "R5 leave A");
        step(1, 0, 0, 0, 0, "R9 idle holds left code");
        step(1, 0, 0, 1, 1, "R5 leave B");
        step(1, 0, 0, 1, 1, "R5 leave B to zero");
        step(1, 0, 0, 1, 1, "R6 leave B at zero");
        step(1, 0, 0, 1, 1, "R6 leave B at zero again");
        step(1, 1, 1, 1, 0, "R7 arrive B with leave A");
        step(1, 1, 0, 1, 0, "R7 arrive A with leave A");
        step(1, 1, 0, 1, 0, "R7 A full with leave A");
        step(1, 1, 1, 1, 1, "R7 arrive B with leave B");
        for (int i = 0; i < 6; i++) step(1, 0, 0, 1, 0, "R6 drain A");
        for (int i = 0; i < 5; i++) step(1, 1, 1, 0, 0, "R2 fill B");
        step(1, 1, 1, 0, 0, "R4 B full");
        step(1, 1, 0, 0, 0, "R3 A free while B full");
        step(0, 1, 1, 0, 0, "R1 reset mid-run");
        step(1, 1, 1, 0, 0, "R1 count restarts");
        step(1, 0, 0, 0, 0, "R9 idle");
        @(negedge clk); arr_vld = 1'b0; dep_vld = 1'b0;
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule